// File: doc/BRIEF.md
# Crossing Slot Validity and Expiry Controller

This controller looks after one slot of a ring of per-crossing buffers. Hits arrive in a fast write clock domain, and each hit word carries the high bits of the crossing counter it belongs to. When a hit opens a new crossing, the controller clears the slot storage. A hit opens a new crossing when the slot holds nothing valid, or when its crossing bits differ from the ones stored. The controller then marks the slot valid and passes the hit on to the storage after a fixed delay, which lets the storage recover from the clear.

A timer runs on the crossing clock and decides how long the slot contents stay usable. Each new crossing restarts it. When it runs out, the contents count as expired and the write side drops its valid flag. A read request is sampled on the falling edge of the crossing clock and acted on at the next rising edge. It reaches the read clock domain as a fast read enable only if the slot is still live. That enable stays high until the storage shows a word whose bit 0 is low, which means the data has run out.

Every single-bit signal that crosses between domains passes through a two-flop synchronizer. Events that cross between domains are carried as toggles.

Top module: `slot_expiry_ctrl`

## Requirements
- R1: While `wr_rst` is high, `stg_rst` reads high on the write clock edge after it is sampled.
- R2: A write that arrives while the slot is not valid raises `stg_rst` for one write clock (visible after the sampling edge) and makes the slot valid. A second write carrying the same crossing bits [11:10] then leaves `stg_rst` low.
- R3: While the slot is valid, a write whose bits [11:10] differ from the stored ones raises `stg_rst` for one cycle and stores the new bits. A write whose bits match leaves `stg_rst` low.
- R4: Each write shows up on `dly_we`/`dly_data` exactly 4 write clocks after its sampling edge. `dly_we` stays low on the three cycles before that, which covers the storage recovery window after `stg_rst`.
- R5: When no write is presented, `dly_we` stays low.
- R6: A read request to a live slot makes `rd_en` rise within a bounded number of read clocks.
- R7: `rd_en` stays high while `rd_lsb` is high, and falls on the read clock edge after `rd_lsb` is seen low.
- R8: Once `EXPIRE_XINGS` crossing clocks have passed since the last new crossing, the slot has expired and a read request leaves `rd_en` low.
- R9: After expiry, the valid flag clears, so the next write, even with the same crossing bits, raises `stg_rst`.
- R10: A new crossing restarts the expiry count, so the slot stays readable for `EXPIRE_XINGS` crossings counted from the latest new crossing.
- R11: One request gives exactly one `rd_en` burst. After it ends, `rd_en` stays low until another request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous reset of the write domain; also forces the storage clear |
| wr_en | input | 1 | Hit write strobe |
| wr_data | input | DATA_W | Hit word; bits [11:10] hold the high crossing bits |
| stg_rst | output | 1 | Registered storage clear |
| dly_we | output | 1 | Delayed write enable to storage |
| dly_data | output | DATA_W | Delayed write data to storage |
| xing_clk | input | 1 | Crossing clock |
| xing_rst | input | 1 | Synchronous reset of the crossing domain |
| rd_req | input | 1 | Read request, sampled on the falling crossing clock edge |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous reset of the read domain |
| rd_lsb | input | 1 | Bit 0 of the storage output word (low when the data has run out) |
| rd_en | output | 1 | Fast read enable to storage |

## Verification
The bench runs every ordered pair of the four crossing-bit values through a live slot. A compare on the wrong bits, or a compare that ignored the stored value, would clear the storage at the wrong times. It lets the slot expire and then both reads and writes, which catches an expiry counter that never stops and a valid flag that never clears. It moves to a new crossing partway through the window and reads after the first window would have ended, which catches a timer that is not restarted. It also watches the read enable for early or late release and for a second burst after `rd_lsb` falls.

// File: rtl/xring_pkg.sv
package xring_pkg;

  // Minimum synchronizer depth allowed on any domain crossing.
  localparam int SYNC_MIN = 2;

  // An event carried as a toggle is seen when the synced value moves.
  function automatic logic toggle_seen(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/slot_delay_line.sv
module slot_delay_line #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_in,
  input  logic [W-1:0] d_in,
  output logic         we_out,
  output logic [W-1:0] d_out
);
  logic [DEPTH-1:0] we_q;
  logic [W-1:0]     d_q [DEPTH];

  // Enable chain is reset; the data chain is left without a reset so it can map to shift-register cells.
  always_ff @(posedge clk) begin
    if (rst) we_q <= '0;
    else     we_q <= {we_q[DEPTH-2:0], we_in};
  end

  always_ff @(posedge clk) begin
    d_q[0] <= d_in;
    for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
  end

  assign we_out = we_q[DEPTH-1];
  assign d_out  = d_q[DEPTH-1];
endmodule

// File: rtl/slot_wr_ctrl.sv
module slot_wr_ctrl
  import xring_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int HB_LO       = 10,
  parameter int HB_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              live_async,
  output logic              stg_rst,
  output logic              start_tgl,
  output logic              valid_q
);
  logic [HB_W-1:0] hb_q;
  logic [HB_W-1:0] hb_in;
  logic            live_s, live_d;
  logic            new_xing, live_fall;

  slot_sync #(.STAGES(SYNC_STAGES)) u_live_sync (
    .clk(clk), .rst(rst), .d(live_async), .q(live_s)
  );

  assign hb_in     = wr_data[HB_LO +: HB_W];
  assign new_xing  = wr_en & (~valid_q | (hb_in != hb_q));
  assign live_fall = live_d & ~live_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_rst   <= 1'b1;
      valid_q   <= 1'b0;
      hb_q      <= '0;
      start_tgl <= 1'b0;
      live_d    <= 1'b0;
    end else begin
      stg_rst <= new_xing;
      live_d  <= live_s;
      if (new_xing) begin
        valid_q   <= 1'b1;
        hb_q      <= hb_in;
        start_tgl <= ~start_tgl;
      end else if (live_fall) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slot_xing_timer.sv
module slot_xing_timer
  import xring_pkg::*;
#(
  parameter int EXPIRE_XINGS = 60,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_async,
  input  logic rd_req,
  output logic live_q,
  output logic rd_tgl,
  output logic [$clog2(EXPIRE_XINGS)-1:0] cnt_q
);
  localparam int CNT_W = $clog2(EXPIRE_XINGS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXPIRE_XINGS - 1);

  logic start_s, start_d, start_evt;
  logic req_n;

  slot_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk(clk), .rst(rst), .d(start_async), .q(start_s)
  );

  assign start_evt = toggle_seen(start_s, start_d);

  // Request captured on the falling edge, used on the next rising edge.
  always_ff @(negedge clk) begin
    if (rst) req_n <= 1'b0;
    else     req_n <= rd_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_d <= 1'b0;
      live_q  <= 1'b0;
      cnt_q   <= '0;
      rd_tgl  <= 1'b0;
    end else begin
      start_d <= start_s;
      if (start_evt) begin
        live_q <= 1'b1;
        cnt_q  <= '0;
      end else if (live_q) begin
        if (cnt_q == LAST) begin
          live_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (req_n && live_q) rd_tgl <= ~rd_tgl;
    end
  end
endmodule

// File: rtl/slot_rd_strobe.sv
module slot_rd_strobe
  import xring_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  input  logic rd_lsb,
  output logic rd_en
);
  logic tg_s, tg_d;

  slot_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk(clk), .rst(rst), .d(strobe_async), .q(tg_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tg_d  <= 1'b0;
      rd_en <= 1'b0;
    end else begin
      tg_d <= tg_s;
      if (rd_en && !rd_lsb)            rd_en <= 1'b0;
      else if (toggle_seen(tg_s, tg_d)) rd_en <= 1'b1;
    end
  end
endmodule

// File: rtl/slot_expiry_ctrl.sv
module slot_expiry_ctrl
  import xring_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int HB_LO        = 10,
  parameter int HB_W         = 2,
  parameter int WR_DELAY     = 4,
  parameter int EXPIRE_XINGS = 60,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              stg_rst,
  output logic              dly_we,
  output logic [DATA_W-1:0] dly_data,
  input  logic              xing_clk,
  input  logic              xing_rst,
  input  logic              rd_req,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_lsb,
  output logic              rd_en
);
  localparam int SYNC_N = (SYNC_STAGES < SYNC_MIN) ? SYNC_MIN : SYNC_STAGES;
  localparam int CNT_W  = $clog2(EXPIRE_XINGS);

  logic             start_tgl, live, strobe_tgl, valid;
  logic [CNT_W-1:0] xing_cnt;

  slot_wr_ctrl #(
    .DATA_W(DATA_W), .HB_LO(HB_LO), .HB_W(HB_W), .SYNC_STAGES(SYNC_N)
  ) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .live_async(live), .stg_rst(stg_rst), .start_tgl(start_tgl), .valid_q(valid)
  );

  slot_delay_line #(.W(DATA_W), .DEPTH(WR_DELAY)) u_dly (
    .clk(wr_clk), .rst(wr_rst), .we_in(wr_en), .d_in(wr_data),
    .we_out(dly_we), .d_out(dly_data)
  );

  slot_xing_timer #(.EXPIRE_XINGS(EXPIRE_XINGS), .SYNC_STAGES(SYNC_N)) u_xing (
    .clk(xing_clk), .rst(xing_rst), .start_async(start_tgl), .rd_req(rd_req),
    .live_q(live), .rd_tgl(strobe_tgl), .cnt_q(xing_cnt)
  );

  slot_rd_strobe #(.SYNC_STAGES(SYNC_N)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .strobe_async(strobe_tgl), .rd_lsb(rd_lsb), .rd_en(rd_en)
  );
endmodule

// File: rtl/slot_expiry_ctrl_chk.sv
module slot_expiry_ctrl_chk #(
  parameter int EXPIRE_XINGS = 60
) (
  input logic wr_clk,
  input logic wr_rst,
  input logic wr_en,
  input logic stg_rst,
  input logic valid,
  input logic xing_clk,
  input logic xing_rst,
  input logic live,
  input logic strobe_tgl,
  input logic [$clog2(EXPIRE_XINGS)-1:0] xing_cnt,
  input logic rd_clk,
  input logic rd_rst,
  input logic rd_lsb,
  input logic rd_en
);
  // R1: reset of the write domain forces the storage clear on the next edge
  assert_global_clear_R1: assert property (@(posedge wr_clk) wr_rst |=> stg_rst);

  // R2: any accepted write leaves the slot valid
  assert_valid_after_hit_R2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_en |=> valid);

  // R7: exhausted data ends the read enable
  assert_rd_release_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && !rd_lsb) |=> !rd_en);

  // R8: a strobe is only launched while the slot is live
  assert_strobe_needs_live_R8: assert property (@(posedge xing_clk) disable iff (xing_rst)
    (strobe_tgl != $past(strobe_tgl)) |-> $past(live));

  // R10: the expiry count never passes its limit
  assert_count_bound_R10: assert property (@(posedge xing_clk) disable iff (xing_rst)
    xing_cnt <= ($clog2(EXPIRE_XINGS))'(EXPIRE_XINGS - 1));
endmodule

bind slot_expiry_ctrl slot_expiry_ctrl_chk #(.EXPIRE_XINGS(EXPIRE_XINGS)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .stg_rst(stg_rst), .valid(valid),
  .xing_clk(xing_clk), .xing_rst(xing_rst), .live(live), .strobe_tgl(strobe_tgl),
  .xing_cnt(xing_cnt), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_lsb(rd_lsb), .rd_en(rd_en)
);

// File: tb/tb_slot_expiry_ctrl.sv
module tb_slot_expiry_ctrl;
  localparam int CLK_PERIOD  = 10;
  localparam int RD_PERIOD   = 8;
  localparam int XING_PERIOD = 100;
  localparam int DW          = 24;
  localparam int EXP         = 20;

  logic wr_clk = 0, rd_clk = 0, xing_clk = 0;
  logic wr_rst = 1, rd_rst = 1, xing_rst = 1;
  logic wr_en = 0, rd_req = 0, rd_lsb = 1;
  logic [DW-1:0] wr_data = '0;
  logic stg_rst, dly_we, rd_en;
  logic [DW-1:0] dly_data;

  int checks = 0, errors = 0, serial = 0;
  bit done = 0;

  always #(CLK_PERIOD/2)  wr_clk   = ~wr_clk;
  always #(RD_PERIOD/2)   rd_clk   = ~rd_clk;
  always #(XING_PERIOD/2) xing_clk = ~xing_clk;

  slot_expiry_ctrl #(.DATA_W(DW), .EXPIRE_XINGS(EXP)) dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .stg_rst(stg_rst), .dly_we(dly_we), .dly_data(dly_data),
    .xing_clk(xing_clk), .xing_rst(xing_rst), .rd_req(rd_req),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_lsb(rd_lsb), .rd_en(rd_en)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One hit with crossing bits hb; checks clear pulse and the 4-cycle delay (R4).
  task automatic hit(input logic [1:0] hb, input logic exp_rst, input string req);
    logic [DW-1:0] d;
    serial++;
    d = DW'((serial << 12) | (int'(hb) << 10) | 1);
    @(negedge wr_clk); wr_en = 1; wr_data = d;
    @(negedge wr_clk); wr_en = 0;
    check(stg_rst == exp_rst, req, 32'(stg_rst), 32'(exp_rst));
    check(dly_we == 0, "R4 early", 32'(dly_we), 0);
    @(negedge wr_clk); check(dly_we == 0, "R4 early", 32'(dly_we), 0);
    @(negedge wr_clk); check(dly_we == 0, "R4 early", 32'(dly_we), 0);
    @(negedge wr_clk);
    check(dly_we == 1, "R4 we", 32'(dly_we), 1);
    check(dly_data == d, "R4 data", 32'(dly_data), 32'(d));
    @(negedge wr_clk); check(dly_we == 0, "R5 idle", 32'(dly_we), 0);
  endtask

  task automatic request();
    @(posedge xing_clk); #1 rd_req = 1;
    @(posedge xing_clk); #1 rd_req = 0;
  endtask

  task automatic wait_rise(input string req);
    bit got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge rd_clk);
      if (rd_en) begin got = 1; break; end
    end
    check(got, req, 32'(got), 1);
  endtask

  task automatic release_rd(input string req);
    @(negedge rd_clk); rd_lsb = 0;
    @(negedge rd_clk); check(rd_en == 0, req, 32'(rd_en), 0);
    rd_lsb = 1;
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] prev;
    bit stay;
    repeat (3) @(posedge xing_clk);
    @(negedge wr_clk);
    check(stg_rst == 1, "R1 reset", 32'(stg_rst), 1);
    check(dly_we == 0, "R5 reset", 32'(dly_we), 0);
    wr_rst = 0; rd_rst = 0; xing_rst = 0;
    @(negedge wr_clk);
    check(stg_rst == 0, "R1 release", 32'(stg_rst), 0);
    check(rd_en == 0, "R11 reset", 32'(rd_en), 0);

    hit(2'd1, 1'b1, "R2 first hit");
    hit(2'd1, 1'b0, "R2 same crossing");

    // R3 sweep over every ordered pair of crossing bits.
    prev = 2'd1;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        hit(2'(a), logic'(2'(a) != prev), "R3 pair first");
        hit(2'(b), logic'(b != a), "R3 pair second");
        prev = 2'(b);
      end
    end

    // R6/R7/R11 read on live slot.
    repeat (5) @(posedge xing_clk);
    request();
    wait_rise("R6 rise");
    stay = 1;
    for (int i = 0; i < 5; i++) begin @(negedge rd_clk); if (!rd_en) stay = 0; end
    check(stay, "R7 hold", 32'(stay), 1);
    release_rd("R7 release");
    stay = 1;
    for (int i = 0; i < 30; i++) begin @(negedge rd_clk); if (rd_en) stay = 0; end
    check(stay, "R11 single burst", 32'(!stay), 0);

    // R8 expiry suppresses request.
    repeat (EXP + 8) @(posedge xing_clk);
    request();
    stay = 1;
    for (int i = 0; i < 60; i++) begin @(negedge rd_clk); if (rd_en) stay = 0; end
    check(stay, "R8 expired", 32'(!stay), 0);

    // R9 valid cleared after expiry.
    hit(prev, 1'b1, "R9 after expiry");

    // R10 restart on new crossing.
    repeat (14) @(posedge xing_clk);
    hit(prev + 2'd1, 1'b1, "R10 new crossing");
    prev = prev + 2'd1;
    repeat (14) @(posedge xing_clk);
    request();
    wait_rise("R10 restarted window");
    release_rd("R7 release again");

    // R1 mid-run global reset, then valid cleared.
    @(negedge wr_clk); wr_rst = 1;
    @(negedge wr_clk); wr_rst = 0;
    check(stg_rst == 1, "R1 mid-run", 32'(stg_rst), 1);
    @(negedge wr_clk);
    hit(prev, 1'b1, "R2 after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule